// File: doc/BRIEF.md
# Look-ahead DRAM Bank Manager

This block schedules commands for a multi-bank SDRAM from a small queue of read and write requests. Requests leave the queue strictly in arrival order. Each request carries a bank, a row, a column, a direction flag and an optional caller-forced auto-precharge. The block keeps the open row and the activate, precharge and row-active timers of every bank. Each cycle it places at most one command on a registered command output.

The request at the head of the queue always takes the command slot when one of its commands is legal. That command is an activate, a precharge of a conflicting row, or the read or write itself. When the head is stalled on a timer, the free slot goes to bank preparation for a later queued request: an early activate, or a precharge of a row that request does not want. Before a read or write is issued, the block scans the rest of the queue for the next request to the same bank. It attaches auto-precharge when that request wants a different row, and leaves the row open when it hits the same row. A caller's auto-precharge request is always honoured.

Top module: `bank_lookahead_sched`

## Requirements
- R1: Command codes are NOP=0, ACT=1, PRE=2, RD=3, WR=4, RDA=5 (read with auto-precharge), WRA=6 (write with auto-precharge). After reset the output is NOP, no bank is open and `req_ready_o` is 1.
- R2: Read and write commands appear in request arrival order, each with its own request's bank and column, and only to a bank whose open row equals the request's row.
- R3: A read or write to a bank is issued at least TRCD cycles after that bank's ACT.
- R4: A PRE to a bank comes at least TRAS cycles after its ACT. An ACT comes at least TRP cycles after a PRE to that bank. After an RDA or WRA issued in cycle k, the next ACT comes no earlier than max(k, last ACT + TRAS) + TRP.
- R5: ACT goes only to a closed bank and PRE only to an open bank.
- R6: When the head request has a legal command (read/write on a row hit, PRE on a row conflict, ACT to a closed bank), that command is issued in the slot.
- R7: When the head has no legal command, the slot goes to the earliest later request whose bank no earlier queued request uses and whose bank can legally be prepared: an ACT with its row if the bank is closed, or a PRE if the bank has another row open.
- R8: A read or write gets auto-precharge (RDA/WRA) when the next queued request to the same bank wants a different row.
- R9: When the next queued request to the same bank hits the same row, or no such request is queued, no auto-precharge is attached unless the caller asked for one.
- R10: A request whose caller auto-precharge bit is set is always issued as RDA or WRA.
- R11: `req_ready_o` is 0 exactly when the queue holds DEPTH requests, and every request accepted while ready is issued.
- R12: The output is NOP when the queue is empty or no queued request has a legal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request offered this cycle |
| req_ready_o | output | 1 | Queue can accept a request |
| req_bank_i | input | $clog2(NUM_BANKS) | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_autopre_i | input | 1 | Caller forces auto-precharge |
| cmd_o | output | 3 | Command code (see R1) |
| cmd_bank_o | output | $clog2(NUM_BANKS) | Command bank |
| cmd_row_o | output | ROW_W | Row for ACT; request row for reads/writes |
| cmd_col_o | output | COL_W | Column for reads/writes |

## Verification
The bench targets these cases:
- A head request waiting out TRCD while a later request's bank is closed. A design without look-ahead would leave NOPs there.
- Two queued requests to the same bank, once with different rows and once with the same row. A wrong auto-precharge choice shows up as a RD where RDA belongs, or as a later needless ACT.
- A later request whose bank is also wanted by an earlier queued entry. Preparing it would wrongly precharge a row the earlier entry still needs.
- The ACT that follows an auto-precharge close while TRAS is still running. An early ACT breaks the combined TRAS plus TRP window.

// File: rtl/lab_pkg.sv
package lab_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_RDA = 3'd5,
        CMD_WRA = 3'd6
    } cmd_e;

    function automatic cmd_e col_cmd(input logic wr, input logic ap);
        if (wr) return ap ? CMD_WRA : CMD_WR;
        return ap ? CMD_RDA : CMD_RD;
    endfunction

    function automatic logic is_col(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR) || (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

    function automatic logic is_autopre(input cmd_e c);
        return (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

endpackage

// File: rtl/lab_req_queue.sv
module lab_req_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       push_i,
    input  logic [W-1:0]               din_i,
    input  logic                       pop_i,
    output logic [DEPTH-1:0][W-1:0]    ent_o,
    output logic [DEPTH-1:0]           vld_o,
    output logic                       full_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][W-1:0] mem_q, mem_d;
    logic [CW-1:0]           cnt_q, cnt_d, after_pop;

    always_comb begin
        mem_d     = mem_q;
        after_pop = cnt_q - CW'(pop_i);
        if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i+1];
        end
        if (push_i) mem_d[after_pop] = din_i;
        cnt_d = after_pop + CW'(push_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            mem_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_vld
            assign vld_o[g] = (CW'(g) < cnt_q);
        end
    endgenerate

    assign ent_o  = mem_q;
    assign full_o = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/lab_bank_timer.sv
module lab_bank_timer #(
    parameter int ROW_W = 14,
    parameter int TRCD  = 3,
    parameter int TRP   = 3,
    parameter int TRAS  = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             apre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rcd_ok_o,
    output logic             ras_ok_o,
    output logic             rp_ok_o
);
    localparam int CNT_W = $clog2(TRAS + TRP + 1) + 1;

    logic [CNT_W-1:0] rcd_q, ras_q, rp_q;
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            open_q <= 1'b0;
            row_q  <= '0;
            rcd_q  <= '0;
            ras_q  <= '0;
            rp_q   <= '0;
        end else begin
            rcd_q <= dec(rcd_q);
            ras_q <= dec(ras_q);
            rp_q  <= dec(rp_q);
            if (act_i) begin
                open_q <= 1'b1;
                row_q  <= row_i;
                rcd_q  <= CNT_W'(TRCD - 1);
                ras_q  <= CNT_W'(TRAS - 1);
            end else if (pre_i) begin
                open_q <= 1'b0;
                rp_q   <= CNT_W'(TRP - 1);
            end else if (apre_i) begin
                // internal precharge waits for the row-active window first
                open_q <= 1'b0;
                rp_q   <= ras_q + CNT_W'(TRP - 1);
            end
        end
    end

    assign open_o   = open_q;
    assign row_o    = row_q;
    assign rcd_ok_o = (rcd_q == '0);
    assign ras_ok_o = (ras_q == '0);
    assign rp_ok_o  = (rp_q == '0);

endmodule

// File: rtl/lab_pick.sv
module lab_pick
    import lab_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int DEPTH     = 4
) (
    input  logic [DEPTH-1:0][1+1+$clog2(NUM_BANKS)+ROW_W+COL_W-1:0] ent_i,
    input  logic [DEPTH-1:0]                  vld_i,
    input  logic [NUM_BANKS-1:0]              open_i,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0]   rows_i,
    input  logic [NUM_BANKS-1:0]              rcd_ok_i,
    input  logic [NUM_BANKS-1:0]              ras_ok_i,
    input  logic [NUM_BANKS-1:0]              rp_ok_i,
    output cmd_e                              cmd_o,
    output logic [$clog2(NUM_BANKS)-1:0]      bank_o,
    output logic [ROW_W-1:0]                  row_o,
    output logic [COL_W-1:0]                  col_o,
    output logic                              pop_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    typedef struct packed {
        logic              wr;
        logic              ap;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } req_t;

    req_t                 h, e;
    logic                 same_seen, row_miss, head_go, found;
    logic [NUM_BANKS-1:0] seen;

    always_comb begin
        cmd_o     = CMD_NOP;
        bank_o    = '0;
        row_o     = '0;
        col_o     = '0;
        pop_o     = 1'b0;
        same_seen = 1'b0;
        row_miss  = 1'b0;
        found     = 1'b0;
        seen      = '0;
        h         = req_t'(ent_i[0]);
        e         = '0;
        if (vld_i[0]) begin
            // look ahead for the next request to the head's bank
            for (int i = 1; i < DEPTH; i++) begin
                e = req_t'(ent_i[i]);
                if (vld_i[i] && !same_seen && (e.bank == h.bank)) begin
                    same_seen = 1'b1;
                    row_miss  = (e.row != h.row);
                end
            end
            if (open_i[h.bank]) begin
                if (rows_i[h.bank] == h.row) begin
                    if (rcd_ok_i[h.bank]) begin
                        cmd_o  = col_cmd(h.wr, h.ap | row_miss);
                        bank_o = h.bank;
                        row_o  = h.row;
                        col_o  = h.col;
                        pop_o  = 1'b1;
                    end
                end else if (ras_ok_i[h.bank]) begin
                    cmd_o  = CMD_PRE;
                    bank_o = h.bank;
                end
            end else if (rp_ok_i[h.bank]) begin
                cmd_o  = CMD_ACT;
                bank_o = h.bank;
                row_o  = h.row;
            end
        end
        head_go = (cmd_o != CMD_NOP);
        if (vld_i[0]) seen[h.bank] = 1'b1;
        // bank preparation for later entries in idle slots
        for (int i = 1; i < DEPTH; i++) begin
            e = req_t'(ent_i[i]);
            if (vld_i[i] && !head_go && !found && !seen[e.bank]) begin
                if (!open_i[e.bank] && rp_ok_i[e.bank]) begin
                    found  = 1'b1;
                    cmd_o  = CMD_ACT;
                    bank_o = e.bank;
                    row_o  = e.row;
                end else if (open_i[e.bank] && (rows_i[e.bank] != e.row) && ras_ok_i[e.bank]) begin
                    found  = 1'b1;
                    cmd_o  = CMD_PRE;
                    bank_o = e.bank;
                end
            end
            if (vld_i[i]) seen[e.bank] = 1'b1;
        end
    end

endmodule

// File: rtl/bank_lookahead_sched.sv
module bank_lookahead_sched
    import lab_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int DEPTH     = 4,
    parameter int TRCD      = 3,
    parameter int TRP       = 3,
    parameter int TRAS      = 6
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         req_valid_i,
    output logic                         req_ready_o,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank_i,
    input  logic [ROW_W-1:0]             req_row_i,
    input  logic [COL_W-1:0]             req_col_i,
    input  logic                         req_write_i,
    input  logic                         req_autopre_i,
    output logic [2:0]                   cmd_o,
    output logic [$clog2(NUM_BANKS)-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]             cmd_row_o,
    output logic [COL_W-1:0]             cmd_col_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int REQ_W  = 2 + BANK_W + ROW_W + COL_W;

    logic [DEPTH-1:0][REQ_W-1:0]        ent;
    logic [DEPTH-1:0]                   vld;
    logic                               full, push, pop;
    logic [NUM_BANKS-1:0]               open_v, rcd_ok, ras_ok, rp_ok;
    logic [NUM_BANKS-1:0][ROW_W-1:0]    rows;
    cmd_e                               nxt_cmd, cmd_q;
    logic [BANK_W-1:0]                  nxt_bank, bank_q;
    logic [ROW_W-1:0]                   nxt_row, row_q;
    logic [COL_W-1:0]                   nxt_col, col_q;

    assign push        = req_valid_i && !full;
    assign req_ready_o = !full;

    lab_req_queue #(.DEPTH(DEPTH), .W(REQ_W)) queue_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .push_i (push),
        .din_i  ({req_write_i, req_autopre_i, req_bank_i, req_row_i, req_col_i}),
        .pop_i  (pop),
        .ent_o  (ent),
        .vld_o  (vld),
        .full_o (full)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit = (nxt_bank == BANK_W'(b));
            lab_bank_timer #(.ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS)) timer_i (
                .clk_i    (clk_i),
                .rst_i    (rst_i),
                .act_i    (hit && (nxt_cmd == CMD_ACT)),
                .pre_i    (hit && (nxt_cmd == CMD_PRE)),
                .apre_i   (hit && is_autopre(nxt_cmd)),
                .row_i    (nxt_row),
                .open_o   (open_v[b]),
                .row_o    (rows[b]),
                .rcd_ok_o (rcd_ok[b]),
                .ras_ok_o (ras_ok[b]),
                .rp_ok_o  (rp_ok[b])
            );
        end
    endgenerate

    lab_pick #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(DEPTH)) pick_i (
        .ent_i    (ent),
        .vld_i    (vld),
        .open_i   (open_v),
        .rows_i   (rows),
        .rcd_ok_i (rcd_ok),
        .ras_ok_i (ras_ok),
        .rp_ok_i  (rp_ok),
        .cmd_o    (nxt_cmd),
        .bank_o   (nxt_bank),
        .row_o    (nxt_row),
        .col_o    (nxt_col),
        .pop_o    (pop)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
        end else begin
            cmd_q  <= nxt_cmd;
            bank_q <= nxt_bank;
            row_q  <= nxt_row;
            col_q  <= nxt_col;
        end
    end

    assign cmd_o      = cmd_q;
    assign cmd_bank_o = bank_q;
    assign cmd_row_o  = row_q;
    assign cmd_col_o  = col_q;

endmodule

// File: rtl/bank_lookahead_sched_chk.sv
module bank_lookahead_sched_chk #(
    parameter int NB    = 8,
    parameter int ROW_W = 14,
    parameter int TRCD  = 3,
    parameter int TRP   = 3,
    parameter int TRAS  = 6
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic [2:0]            cmd_o,
    input logic [$clog2(NB)-1:0] cmd_bank_o,
    input logic [ROW_W-1:0]      cmd_row_o
);
    localparam int BW = $clog2(NB);

    logic [7:0]       since_act   [NB];
    logic [7:0]       since_close [NB];
    logic             is_open     [NB];
    logic [ROW_W-1:0] open_row    [NB];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int b = 0; b < NB; b++) begin
                since_act[b]   <= 8'hFF;
                since_close[b] <= 8'hFF;
                is_open[b]     <= 1'b0;
                open_row[b]    <= '0;
            end
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (since_act[b] != 8'hFF) since_act[b] <= since_act[b] + 8'd1;
                if (since_close[b] != 8'hFF) since_close[b] <= since_close[b] + 8'd1;
                if (cmd_bank_o == BW'(b)) begin
                    if (cmd_o == 3'd1) begin
                        since_act[b] <= 8'd1;
                        is_open[b]   <= 1'b1;
                        open_row[b]  <= cmd_row_o;
                    end else if (cmd_o == 3'd2 || cmd_o == 3'd5 || cmd_o == 3'd6) begin
                        since_close[b] <= 8'd1;
                        is_open[b]     <= 1'b0;
                    end
                end
            end
        end
    end

    generate
        for (genvar b = 0; b < NB; b++) begin : g_b
            logic sel, col;
            assign sel = (cmd_bank_o == BW'(b));
            assign col = (cmd_o >= 3'd3) && (cmd_o <= 3'd6);

            a_r3_rcd_gap: assert property (@(posedge clk_i) disable iff (rst_i)
                (sel && col) |-> (since_act[b] >= 8'(TRCD)));

            a_r4_ras_gap: assert property (@(posedge clk_i) disable iff (rst_i)
                (sel && cmd_o == 3'd2) |-> (since_act[b] >= 8'(TRAS)));

            a_r4_rp_gap: assert property (@(posedge clk_i) disable iff (rst_i)
                (sel && cmd_o == 3'd1) |-> (since_close[b] >= 8'(TRP)));

            a_r5_act_closed: assert property (@(posedge clk_i) disable iff (rst_i)
                (sel && cmd_o == 3'd1) |-> !is_open[b]);

            a_r5_pre_open: assert property (@(posedge clk_i) disable iff (rst_i)
                (sel && cmd_o == 3'd2) |-> is_open[b]);

            a_r2_row_hit: assert property (@(posedge clk_i) disable iff (rst_i)
                (sel && col) |-> (is_open[b] && open_row[b] == cmd_row_o));
        end
    endgenerate

    a_r1_code_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_o != 3'd7);

endmodule

bind bank_lookahead_sched bank_lookahead_sched_chk #(
    .NB(NUM_BANKS), .ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS)
) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cmd_o      (cmd_o),
    .cmd_bank_o (cmd_bank_o),
    .cmd_row_o  (cmd_row_o)
);

// File: tb/bank_lookahead_sched_tb_top.sv
module bank_lookahead_sched_tb_top;
    localparam int NB = 8, ROW_W = 14, COL_W = 10, DEPTH = 4;
    localparam int TRCD = 3, TRP = 3, TRAS = 6;
    localparam int NPLAN = 300, NDIR = 5;

    logic clk = 1'b0, rst = 1'b1;
    always #10 clk = ~clk;

    logic             req_valid = 1'b0, req_ready, req_write = 1'b0, req_ap = 1'b0;
    logic [2:0]       req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [2:0]       cmd, cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;

    bank_lookahead_sched #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(DEPTH),
                           .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS)) dut_i (
        .clk_i(clk), .rst_i(rst), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
        .req_write_i(req_write), .req_autopre_i(req_ap), .cmd_o(cmd),
        .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col));

    int checks = 0, fails = 0;
    bit done = 1'b0;

    int q_bank[16], q_row[16], q_col[16];
    bit q_wr[16], q_ap[16];
    int q_n = 0;
    bit m_open[NB];
    int m_row[NB], m_act[NB], m_rdy[NB];
    int p_bank[NPLAN], p_row[NPLAN], p_col[NPLAN];
    bit p_wr[NPLAN], p_ap[NPLAN];
    int issued = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // expected command from the requirements and the tracked bank state
    task automatic model_expect(int t, output int ec, output int eb, output int er,
                                output int ecol, output string tag);
        bit seen[NB];
        bit same, diff, ap;
        int b;
        ec = 0; eb = 0; er = 0; ecol = 0; tag = "R12";
        for (int i = 0; i < NB; i++) seen[i] = 1'b0;
        if (q_n == 0) return;
        b = q_bank[0];
        same = 1'b0; diff = 1'b0;
        for (int i = 1; i < q_n; i++)
            if (!same && q_bank[i] == b) begin same = 1'b1; diff = (q_row[i] != q_row[0]); end
        if (m_open[b]) begin
            if (m_row[b] == q_row[0]) begin
                if (t >= m_act[b] + TRCD) begin
                    ap = q_ap[0] || diff;
                    ec = q_wr[0] ? (ap ? 6 : 4) : (ap ? 5 : 3);
                    eb = b; ecol = q_col[0];
                    tag = q_ap[0] ? "R10" : (diff ? "R8" : "R9");
                end
            end else if (t >= m_act[b] + TRAS) begin
                ec = 2; eb = b; tag = "R6";
            end
        end else if (t >= m_rdy[b]) begin
            ec = 1; eb = b; er = q_row[0]; tag = "R6";
        end
        if (ec != 0) return;
        seen[b] = 1'b1;
        for (int i = 1; i < q_n; i++) begin
            int lb = q_bank[i];
            if (ec == 0 && !seen[lb]) begin
                if (!m_open[lb] && t >= m_rdy[lb]) begin
                    ec = 1; eb = lb; er = q_row[i]; tag = "R7";
                end else if (m_open[lb] && m_row[lb] != q_row[i] && t >= m_act[lb] + TRAS) begin
                    ec = 2; eb = lb; tag = "R7";
                end
            end
            seen[lb] = 1'b1;
        end
    endtask

    task automatic process(int t);
        int ec, eb, er, ecol, b;
        string tag;
        model_expect(t, ec, eb, er, ecol, tag);
        chk(int'(cmd) == ec, tag, "command code", int'(cmd), ec);
        if (ec != 0 && int'(cmd) == ec) chk(int'(cmd_bank) == eb, tag, "bank", int'(cmd_bank), eb);
        if (ec == 1 && int'(cmd) == 1) chk(int'(cmd_row) == er, tag, "act row", int'(cmd_row), er);
        b = int'(cmd_bank);
        case (int'(cmd))
            1: begin
                chk(!m_open[b], "R5", "act to open bank", 1, 0);
                chk(t >= m_rdy[b], "R4", "act precharge gap", t, m_rdy[b]);
                m_open[b] = 1'b1; m_row[b] = int'(cmd_row); m_act[b] = t;
            end
            2: begin
                chk(m_open[b], "R5", "pre to closed bank", 0, 1);
                chk(t >= m_act[b] + TRAS, "R4", "pre ras gap", t, m_act[b] + TRAS);
                m_open[b] = 1'b0; m_rdy[b] = t + TRP;
            end
            3, 4, 5, 6: begin
                chk(q_n > 0 && q_bank[0] == b && q_col[0] == int'(cmd_col), "R2",
                    "in-order column", int'(cmd_col), (q_n > 0) ? q_col[0] : -1);
                chk(t >= m_act[b] + TRCD, "R3", "rcd gap", t, m_act[b] + TRCD);
                if (cmd >= 3'd5) begin
                    m_open[b] = 1'b0;
                    m_rdy[b] = imax(t, m_act[b] + TRAS) + TRP;
                end
                for (int i = 0; i < 15; i++) begin
                    q_bank[i] = q_bank[i+1]; q_row[i] = q_row[i+1]; q_col[i] = q_col[i+1];
                    q_wr[i] = q_wr[i+1]; q_ap[i] = q_ap[i+1];
                end
                if (q_n > 0) q_n--;
                issued++;
            end
            default: ;
        endcase
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed: head waits TRCD with a fresh bank behind it, then row miss,
        // row hit and a caller auto-precharge
        p_bank[0] = 0; p_row[0] = 5; p_col[0] = 1; p_wr[0] = 0; p_ap[0] = 0;
        p_bank[1] = 1; p_row[1] = 2; p_col[1] = 2; p_wr[1] = 1; p_ap[1] = 0;
        p_bank[2] = 0; p_row[2] = 7; p_col[2] = 3; p_wr[2] = 0; p_ap[2] = 0;
        p_bank[3] = 0; p_row[3] = 7; p_col[3] = 4; p_wr[3] = 0; p_ap[3] = 0;
        p_bank[4] = 2; p_row[4] = 1; p_col[4] = 5; p_wr[4] = 1; p_ap[4] = 1;
        for (int i = NDIR; i < NPLAN; i++) begin
            p_bank[i] = int'($urandom % 4);
            p_row[i]  = int'($urandom % 3);
            p_col[i]  = int'($urandom % 1024);
            p_wr[i]   = bit'($urandom % 2);
            p_ap[i]   = ($urandom % 8) == 0;
        end
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 1'b0; m_row[b] = 0; m_act[b] = -1000; m_rdy[b] = 0;
        end
    end

    initial begin
        int t = 0, p_idx = 0, idle = 0;
        bit pend = 1'b0;
        int pb = 0, pr = 0, pc = 0;
        bit pw = 1'b0, pa = 1'b0;
        repeat (4) @(negedge clk);
        chk(cmd == 3'd0, "R1", "reset command", int'(cmd), 0);
        chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
        rst = 1'b0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            t++;
            process(t);
            if (pend) begin
                q_bank[q_n] = pb; q_row[q_n] = pr; q_col[q_n] = pc;
                q_wr[q_n] = pw; q_ap[q_n] = pa; q_n++;
                pend = 1'b0;
            end
            chk(req_ready == (q_n < DEPTH), "R11", "ready", int'(req_ready), int'(q_n < DEPTH));
            req_valid = 1'b0;
            if (p_idx < NPLAN && (p_idx < NDIR || ($urandom % 10) < 8)) begin
                req_valid = 1'b1;
                req_bank  = 3'(p_bank[p_idx]);
                req_row   = ROW_W'(p_row[p_idx]);
                req_col   = COL_W'(p_col[p_idx]);
                req_write = p_wr[p_idx];
                req_ap    = p_ap[p_idx];
                if (req_ready) begin
                    pend = 1'b1; pb = p_bank[p_idx]; pr = p_row[p_idx]; pc = p_col[p_idx];
                    pw = p_wr[p_idx]; pa = p_ap[p_idx];
                    p_idx++;
                end
            end
            if (p_idx == NPLAN && q_n == 0 && !pend) idle++;
            if (idle > 20) break;
        end
        chk(issued == NPLAN, "R11", "requests issued", issued, NPLAN);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 30000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule